// File: doc/BRIEF.md
# Prefetch Buffer Victim Selector

This block keeps the replacement bookkeeping for a fully associative prefetch buffer whose entries each hold one whole DRAM row. For every entry it records which cache lines of the held row have been read so far and where the entry sits in a strict recency order. When the surrounding controller needs room for a new row, it raises a fill request and the block names the entry to overwrite one cycle later.

The choice follows a fixed ranking. An entry not holding a row is taken first. Next comes a row whose lines have all been delivered. Failing both, the entry with the smallest sum of distinct-lines-read and recency rank is taken, with the lower line count winning a tied sum. The named entry is then treated as freshly loaded: its line record is cleared and it becomes the most recent entry. Row storage, tag lookup and write-back stay with the controller.

Top module: `pfb_victim_select`

## Requirements
- R1: After reset `victim_valid` is 0, no line of any entry counts as read, and entry i holds recency rank i (0 is least recent, 15 most recent); a first fill with all entries valid therefore names entry 0.
- R2: A fill request sampled at a clock edge drives `victim_valid` high for exactly the following cycle with the chosen index on `victim_idx`; without a fill request `victim_valid` is 0.
- R3: If any bit of `entry_valid` is 0 at the fill edge, the victim is the lowest-numbered entry whose bit is 0.
- R4: Otherwise, if any entry has had all 16 of its lines read, the victim is the lowest-numbered such entry.
- R5: An entry's line count rises by one only when a line of that row not read before is accessed; repeated reads of one line leave it unchanged.
- R6: An access to entry k sets k's rank to 15 and lowers by one the rank of every other entry whose rank was above k's previous rank; the ranks always form a permutation of 0..15.
- R7: Otherwise the victim is the entry with the smallest line count plus rank.
- R8: Among entries sharing the smallest sum, the one with the smaller line count wins; a remaining tie goes to the lowest index.
- R9: The entry named by a fill starts with no line read and takes rank 15, the other ranks moving as for an access (R6).
- R10: An access presented in the same cycle as a fill request is discarded: it marks no line and moves no rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_valid | input | 16 | One bit per entry, 1 when the entry holds a row |
| acc_valid | input | 1 | A demand read hit an entry this cycle |
| acc_entry | input | 4 | Entry that was read |
| acc_line | input | 4 | Line within the row that was read (64-byte lines, 16 per 1 KB row) |
| fill_req | input | 1 | Request for a victim for a new row |
| victim_valid | output | 1 | One-cycle strobe: `victim_idx` is the chosen entry |
| victim_idx | output | 4 | Index of the entry to overwrite |

## Verification
The bench drives a directed tie where an entry with one line read and rank 0 meets an entry with no lines read and rank 1; a selector falling back to lowest index would name the wrong one. Repeated reads of one line and a fill that coincides with the last missing line of a row target a design that counts reads rather than distinct lines or that lets a same-cycle access through; either would later evict that row as fully consumed. A run of back-to-back fills walks the rank order and exposes an update that decrements the wrong entries, since victims then come out of order. A long pseudo-random stretch with occasional invalid entries compares every cycle against a behavioural model.

// File: rtl/pfb_pkg.sv
// Shared types for the prefetch buffer victim selector.
// Assumes nothing beyond being compiled before the modules that import it.
package pfb_pkg;
    // Eviction class of an entry: lower value is evicted first.
    typedef enum logic [1:0] {
        CLS_EMPTY = 2'd0,
        CLS_SPENT = 2'd1,
        CLS_LIVE  = 2'd2
    } pick_class_e;
endpackage

// File: rtl/pfb_line_tracker.sv
// Per-entry record of which lines of the buffered row have been read.
// Produces the distinct-line count and an all-lines-read flag per entry.
// Assumes set and clear never target the same cycle (the top gates set by fill).
module pfb_line_tracker #(
    parameter int N_ENTRIES     = 16,
    parameter int LINES_PER_ROW = 16,
    localparam int EW = $clog2(N_ENTRIES),
    localparam int LW = $clog2(LINES_PER_ROW),
    localparam int UW = $clog2(LINES_PER_ROW + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_en,
    input  logic [EW-1:0]             set_entry,
    input  logic [LW-1:0]             set_line,
    input  logic                      clr_en,
    input  logic [EW-1:0]             clr_entry,
    output logic [N_ENTRIES*UW-1:0]   util_flat,
    output logic [N_ENTRIES-1:0]      full
);
    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
        logic [LINES_PER_ROW-1:0] seen_q;

        // Mark read lines; a fill of this entry wipes the record.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q <= '0;
            end else if (clr_en && clr_entry == EW'(e)) begin
                seen_q <= '0;
            end else if (set_en && set_entry == EW'(e)) begin
                seen_q[set_line] <= 1'b1;
            end
        end

        // Population count of the read-line record.
        always_comb begin
            logic [UW-1:0] cnt;
            cnt = '0;
            for (int b = 0; b < LINES_PER_ROW; b++) begin
                cnt = cnt + UW'(seen_q[b]);
            end
            util_flat[e*UW +: UW] = cnt;
        end

        // Row fully consumed when every line has been read.
        assign full[e] = &seen_q;
    end
endmodule

// File: rtl/pfb_recency_order.sv
// Strict recency ranking of the buffer entries, 0 least and N-1 most recent.
// Assumes ranks start as a permutation; each touch keeps them one.
module pfb_recency_order #(
    parameter int N_ENTRIES = 16,
    localparam int EW = $clog2(N_ENTRIES),
    localparam logic [EW-1:0] TOP_RANK = EW'(N_ENTRIES - 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     touch_en,
    input  logic [EW-1:0]            touch_idx,
    output logic [N_ENTRIES*EW-1:0]  rec_flat
);
    logic [EW-1:0] prev_rank;

    // Rank the touched entry held before this update.
    always_comb begin
        prev_rank = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (touch_idx == EW'(i)) prev_rank = rec_flat[i*EW +: EW];
        end
    end

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_rank
        logic [EW-1:0] rank_q;

        // Promote the touched entry to the top, slide the ones above it down.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rank_q <= EW'(e);
            end else if (touch_en) begin
                if (touch_idx == EW'(e)) begin
                    rank_q <= TOP_RANK;
                end else if (rank_q > prev_rank) begin
                    rank_q <= rank_q - 1'b1;
                end
            end
        end

        assign rec_flat[e*EW +: EW] = rank_q;
    end
endmodule

// File: rtl/pfb_victim_pick.sv
// Combinational victim choice: empty entries, then consumed rows, then the
// smallest line-count plus rank, ties to smaller line count, then lower index.
// Assumes util and rank vectors come from the tracker and recency modules.
module pfb_victim_pick
    import pfb_pkg::*;
#(
    parameter int N_ENTRIES     = 16,
    parameter int LINES_PER_ROW = 16,
    localparam int EW = $clog2(N_ENTRIES),
    localparam int UW = $clog2(LINES_PER_ROW + 1),
    localparam int SW = $clog2(LINES_PER_ROW + N_ENTRIES),
    localparam int KW = 2 + SW + UW
) (
    input  logic [N_ENTRIES-1:0]     entry_valid,
    input  logic [N_ENTRIES*UW-1:0]  util_flat,
    input  logic [N_ENTRIES*EW-1:0]  rec_flat,
    input  logic [N_ENTRIES-1:0]     full,
    output logic [EW-1:0]            pick_idx
);
    logic [KW-1:0] key [N_ENTRIES];

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_key
        // Build a sortable key; class dominates, sum and count only matter when live.
        always_comb begin
            pick_class_e   cls;
            logic [SW-1:0] sum;
            logic [UW-1:0] u;
            u   = util_flat[e*UW +: UW];
            sum = SW'(u) + SW'(rec_flat[e*EW +: EW]);
            if (!entry_valid[e])  cls = CLS_EMPTY;
            else if (full[e])     cls = CLS_SPENT;
            else                  cls = CLS_LIVE;
            if (cls == CLS_LIVE) key[e] = {cls, sum, u};
            else                 key[e] = {cls, {SW{1'b0}}, {UW{1'b0}}};
        end
    end

    // Linear minimum scan; strict compare keeps the lowest index on equal keys.
    always_comb begin
        logic [KW-1:0] best;
        best     = key[0];
        pick_idx = '0;
        for (int i = 1; i < N_ENTRIES; i++) begin
            if (key[i] < best) begin
                best     = key[i];
                pick_idx = EW'(i);
            end
        end
    end
endmodule

// File: rtl/pfb_victim_select.sv
// Replacement state and victim selection for a row-granular prefetch buffer.
// A fill request sampled at an edge yields a one-cycle victim strobe next
// cycle; at the same edge the victim is cleared and made most recent.
// Assumes the controller ignores accesses it issues in a fill cycle.
module pfb_victim_select #(
    parameter int N_ENTRIES     = 16,
    parameter int LINES_PER_ROW = 16,
    localparam int EW = $clog2(N_ENTRIES),
    localparam int LW = $clog2(LINES_PER_ROW),
    localparam int UW = $clog2(LINES_PER_ROW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_ENTRIES-1:0]  entry_valid,
    input  logic                  acc_valid,
    input  logic [EW-1:0]         acc_entry,
    input  logic [LW-1:0]         acc_line,
    input  logic                  fill_req,
    output logic                  victim_valid,
    output logic [EW-1:0]         victim_idx
);
    logic [N_ENTRIES*UW-1:0] util_flat;
    logic [N_ENTRIES*EW-1:0] rec_flat;
    logic [N_ENTRIES-1:0]    full;
    logic [EW-1:0]           pick_idx;
    logic                    touch_en;
    logic [EW-1:0]           touch_idx;
    logic                    mark_en;

    // A fill wins the cycle; a coincident access is dropped.
    assign mark_en   = acc_valid && !fill_req;
    assign touch_en  = acc_valid || fill_req;
    assign touch_idx = fill_req ? pick_idx : acc_entry;

    pfb_line_tracker #(
        .N_ENTRIES    (N_ENTRIES),
        .LINES_PER_ROW(LINES_PER_ROW)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (mark_en),
        .set_entry (acc_entry),
        .set_line  (acc_line),
        .clr_en    (fill_req),
        .clr_entry (pick_idx),
        .util_flat (util_flat),
        .full      (full)
    );

    pfb_recency_order #(
        .N_ENTRIES(N_ENTRIES)
    ) u_rank (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .rec_flat  (rec_flat)
    );

    pfb_victim_pick #(
        .N_ENTRIES    (N_ENTRIES),
        .LINES_PER_ROW(LINES_PER_ROW)
    ) u_pick (
        .entry_valid (entry_valid),
        .util_flat   (util_flat),
        .rec_flat    (rec_flat),
        .full        (full),
        .pick_idx    (pick_idx)
    );

    // Register the choice and the strobe for the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_valid <= 1'b0;
            victim_idx   <= '0;
        end else begin
            victim_valid <= fill_req;
            if (fill_req) victim_idx <= pick_idx;
        end
    end
endmodule

// File: rtl/pfb_victim_select_chk.sv
// Assertion checker for pfb_victim_select, attached by bind below.
// Assumes it sees the top's internal rank and line-count vectors.
module pfb_victim_select_chk #(
    parameter int N_ENTRIES     = 16,
    parameter int LINES_PER_ROW = 16,
    localparam int EW = $clog2(N_ENTRIES),
    localparam int UW = $clog2(LINES_PER_ROW + 1),
    localparam logic [EW-1:0] TOP_RANK = EW'(N_ENTRIES - 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_ENTRIES-1:0]     entry_valid,
    input logic                     fill_req,
    input logic                     victim_valid,
    input logic [EW-1:0]            victim_idx,
    input logic                     touch_en,
    input logic [EW-1:0]            touch_idx,
    input logic [N_ENTRIES*EW-1:0]  rec_flat,
    input logic [N_ENTRIES*UW-1:0]  util_flat
);
    logic [EW-1:0]        rec_a  [N_ENTRIES];
    logic [UW-1:0]        util_a [N_ENTRIES];
    logic [N_ENTRIES-1:0] rank_seen;
    logic [N_ENTRIES-1:0] ev_q;
    logic                 touched_q;
    logic [EW-1:0]        touched_idx_q;

    // Unpack the flat vectors and record which ranks are in use.
    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            rec_a[i]  = rec_flat[i*EW +: EW];
            util_a[i] = util_flat[i*UW +: UW];
            rank_seen[rec_a[i]] = 1'b1;
        end
    end

    // Remember last cycle's valid bits and touch for next-cycle checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q          <= '1;
            touched_q     <= 1'b0;
            touched_idx_q <= '0;
        end else begin
            ev_q          <= entry_valid;
            touched_q     <= touch_en;
            touched_idx_q <= touch_idx;
        end
    end

    // R2
    strobe_follows_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> victim_valid);
    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_req |=> !victim_valid);
    // R3
    empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !(&ev_q)) |-> !ev_q[victim_idx]);
    // R6
    rank_permutation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rank_seen) == N_ENTRIES);
    // R6
    touched_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touched_q |-> rec_a[touched_idx_q] == TOP_RANK);
    // R9
    victim_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (util_a[victim_idx] == '0 && rec_a[victim_idx] == TOP_RANK));
endmodule

bind pfb_victim_select pfb_victim_select_chk #(
    .N_ENTRIES    (N_ENTRIES),
    .LINES_PER_ROW(LINES_PER_ROW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .entry_valid  (entry_valid),
    .fill_req     (fill_req),
    .victim_valid (victim_valid),
    .victim_idx   (victim_idx),
    .touch_en     (touch_en),
    .touch_idx    (touch_idx),
    .rec_flat     (rec_flat),
    .util_flat    (util_flat)
);

// File: tb/pfb_victim_select_test.sv
// Bench: behavioural reference model stepped with the design, compared every cycle.
module pfb_victim_select_test;
    localparam int N = 16;
    localparam int L = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  entry_valid = '1;
    logic          acc_valid = 1'b0;
    logic [3:0]    acc_entry = '0;
    logic [3:0]    acc_line = '0;
    logic          fill_req = 1'b0;
    logic          victim_valid;
    logic [3:0]    victim_idx;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // Reference state
    int         m_rank [N];
    bit [L-1:0] m_seen [N];
    bit         exp_vv;
    int         exp_idx;
    bit [15:0]  lfsr = 16'hACE1;

    pfb_victim_select uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_valid  (entry_valid),
        .acc_valid    (acc_valid),
        .acc_entry    (acc_entry),
        .acc_line     (acc_line),
        .fill_req     (fill_req),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            finish_run();
        end
    end

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_pick(bit [N-1:0] ev);
        int best = -1;
        for (int i = 0; i < N; i++) if (!ev[i]) return i;
        for (int i = 0; i < N; i++) if (&m_seen[i]) return i;
        best = 0;
        for (int i = 1; i < N; i++) begin
            int si = $countones(m_seen[i]) + m_rank[i];
            int sb = $countones(m_seen[best]) + m_rank[best];
            if (si < sb || (si == sb && $countones(m_seen[i]) < $countones(m_seen[best])))
                best = i;
        end
        return best;
    endfunction

    task automatic model_touch(int k);
        int p = m_rank[k];
        for (int i = 0; i < N; i++) begin
            if (i == k) m_rank[i] = N - 1;
            else if (m_rank[i] > p) m_rank[i] = m_rank[i] - 1;
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_rank[i] = i;
            m_seen[i] = '0;
        end
        exp_vv  = 0;
        exp_idx = 0;
    endtask

    // One clock: inputs already driven at a falling edge; update model at the
    // rising edge, compare at the next falling edge.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else if (fill_req) begin
            exp_idx = model_pick(entry_valid);
            exp_vv  = 1;
            m_seen[exp_idx] = '0;
            model_touch(exp_idx);
        end else begin
            exp_vv = 0;
            if (acc_valid) begin
                m_seen[acc_entry][acc_line] = 1'b1;
                model_touch(acc_entry);
            end
        end
        @(negedge clk);
        check(cur_tag, victim_valid, exp_vv, "victim_valid");
        if (exp_vv) check(cur_tag, victim_idx, exp_idx, "victim_idx");
    endtask

    task automatic idle();
        acc_valid = 0; fill_req = 0;
        step();
    endtask

    task automatic access(int e, int ln);
        acc_valid = 1; acc_entry = 4'(e); acc_line = 4'(ln); fill_req = 0;
        step();
        acc_valid = 0;
    endtask

    task automatic fill();
        acc_valid = 0; fill_req = 1;
        step();
        fill_req = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; acc_valid = 0; fill_req = 0; entry_valid = '1;
        step(); step();
        rst_n = 1;
    endtask

    initial begin
        @(negedge clk);
        cur_tag = "R1";
        do_reset();
        idle();
        fill();                       // R1: expect entry 0
        check("R1", victim_idx, 0, "first victim after reset");

        cur_tag = "R2";
        idle();
        fill(); fill(); idle();       // R2: back-to-back strobes, then low

        cur_tag = "R3";
        entry_valid = '1; entry_valid[9] = 0; entry_valid[5] = 0;
        fill();
        check("R3", victim_idx, 5, "lowest empty entry");
        entry_valid = '1;

        cur_tag = "R4";
        for (int ln = 0; ln < L; ln++) access(11, ln);
        for (int ln = 0; ln < L; ln++) access(7, ln);
        fill();
        check("R4", victim_idx, 7, "lowest fully read row");

        cur_tag = "R5";
        do_reset();
        for (int r = 0; r < 20; r++) access(2, 3);   // one distinct line only
        for (int ln = 0; ln < 8; ln++) access(2, ln);
        fill(); fill(); fill();

        cur_tag = "R6";
        access(6, 1); access(1, 1); access(6, 2); access(14, 0);
        fill(); fill();

        cur_tag = "R8";
        do_reset();
        access(0, 0);
        for (int f = 0; f < 15; f++) fill();          // R7 walk of rank-0 entries
        fill();
        check("R8", victim_idx, 1, "tie broken on lower line count");

        cur_tag = "R10";
        do_reset();
        for (int ln = 0; ln < L - 1; ln++) access(9, ln);
        acc_valid = 1; acc_entry = 4'd9; acc_line = 4'd15; fill_req = 1;
        step();
        acc_valid = 0; fill_req = 0;
        fill();
        check("R10", (victim_idx == 4'd9) ? 1 : 0, 0, "coincident access dropped");

        cur_tag = "R9";
        fill(); fill();

        cur_tag = "R7";
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            entry_valid = '1;
            if (lfsr[7:4] == 4'd0) entry_valid[lfsr[11:8]] = 1'b0;
            fill_req  = (lfsr[2:0] == 3'd0);
            acc_valid = lfsr[3];
            acc_entry = lfsr[11:8] ^ lfsr[15:12];
            acc_line  = lfsr[15:12];
            step();
        end
        acc_valid = 0; fill_req = 0; entry_valid = '1;
        idle();

        finish_run();
    end
endmodule